// File: doc/BRIEF.md
# Dual Timer with Match Interrupts

This peripheral holds two independent 16-bit counters. Each has a value register, a prescale divider and a control word. The counters share six compare registers and one interrupt unit. Software loads a counter and writes its control word. The control word says whether the counter runs, which way it counts and where it ends. A counter can count down to zero, count until it equals one chosen compare register, or run forever and wrap. Reaching a compare register latches a status bit for that register. A mask gates the status bits onto one interrupt line.

The block is driven by a simple word-addressed register bus with two regions. Region 0 holds the counters and compare registers. Region 1 holds interrupt status and mask. The bus address is a word index, so byte offset 0xNN is word 0xNN/4. Writes take effect at the clock edge where `bus_wr` is high. A read issued with `bus_rd` at one edge returns its data on `bus_rdata` after that edge.

A typical one-shot use runs like this:
- Set compare register 0 to zero.
- Load the delay into the counter value.
- Write the control word to run, count down and stop at compare 0.
- Unmask status bit 0, then wait for `irq`.

Top module: `dual_match_timer`

## Requirements
- R1: After synchronous reset the state is as follows. Both counter values, both dividers, all compare registers, status and mask read 0. Both control words read 0x10, which means stopped. `irq` is 0.
- R2: Region 0 word map:
  - Counter 0 value, divider and control sit at words 0, 1 and 2.
  - Counter 1 value, divider and control sit at words 3, 4 and 5.
  - Compare register n sits at word 6+n, for n = 0..5.

  Region 1 word map: status is word 0 and mask is word 1. Writing a value word loads the counter directly. A counter whose control bit 4 is 1 keeps its value.
- R3: With control bit 4 clear the counter runs. Control bit 3 = 1 makes it count up and 0 makes it count down.
- R4: A divider value D makes a running counter step once every D+1 clocks. Writing the control word clears the prescaler, and the counter does not step in the cycle of that write. Take the edge of the control write as edge 0. With D = 3 the steps fall on edges 4, 8, 12 and so on.
- R5: Control bits 2:0 = n+1 (n = 0..5) means stop at compare register n. When the running counter equals that register, status bit n is set and the counter holds its value until the control word is written again. The check happens before stepping, so a count-down from N with D = 0 sets the bit at edge N+1 after the control write.
- R6: Control bits 2:0 = 0 counts to zero. The counter holds at 0 and sets no status bit.
- R7: Control bits 2:0 = 7 runs forever. The counter never holds and wraps modulo 2^16 in both directions.
- R8: `irq` is the registered OR over all six bits of (status AND mask). A status bit is still latched while its mask bit is 0.
- R9: Writing region 1 word 0 clears each status bit written as 1. Bits written as 0 are left as they are, and 0x3F clears all six.
- R10: A compare event and a write-one clear hitting the same status bit in the same cycle leave the bit set.
- R11: The two counters run independently and either one can select any compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears after the edge |
| bus_region | input | 1 | 0 = counters/compare, 1 = interrupt unit |
| bus_word | input | 4 | Word address within the region |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt line, high when an unmasked status bit is set |

## Verification
The assertions rely on three conditions on the inputs:
- `bus_wr` and `bus_rd` are never undefined after reset.
- A write to a stopped counter's own value word is the only thing that may change that value.
- At most one compare event per counter happens per cycle.

The stimulus issues one bus operation at a time, each lasting exactly one clock. Results are read only from stopped or holding counters, so every read value is fixed. The one case that needs an exact edge, a clear landing on the compare event, is timed from the control write by counting idle cycles.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int CTRL_W = 5;
  localparam logic [2:0] MODE_ZERO    = 3'd0;
  localparam logic [2:0] MODE_FOREVER = 3'd7;

  typedef struct packed {
    logic       stop;
    logic       up;
    logic [2:0] mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{stop: 1'b1, up: 1'b0, mode: MODE_ZERO};
endpackage

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int W  = 16,
  parameter int NM = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_cur,
  input  logic                  ld_div,
  input  logic                  ld_ctrl,
  input  logic [W-1:0]          wdata,
  input  logic [NM-1:0][W-1:0]  match_vals,
  output logic [W-1:0]          cur,
  output logic [W-1:0]          div,
  output ctrl_t                 ctrl,
  output logic [NM-1:0]         hit
);
  logic [W-1:0] pre;
  logic         held;
  logic [W-1:0] target;
  logic         counting;
  logic         event_now;
  logic         tick;

  // Target of the current mode: zero by default, a compare register when selected
  always_comb begin
    target = '0;
    for (int i = 0; i < NM; i++) begin
      if (ctrl.mode == 3'(i + 1)) target = match_vals[i];
    end
  end

  assign counting  = !ctrl.stop && !held && !ld_ctrl;
  assign event_now = counting && (ctrl.mode != MODE_FOREVER) && (cur == target);
  assign tick      = (pre == div);

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      hit[i] = event_now && (ctrl.mode == 3'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      div  <= '0;
      ctrl <= CTRL_RESET;
      pre  <= '0;
      held <= 1'b0;
    end else begin
      if (ld_ctrl) begin
        ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        pre  <= '0;
        held <= 1'b0;
      end else if (event_now) begin
        held <= 1'b1;
      end else if (counting) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cur <= ctrl.up ? cur + 1'b1 : cur - 1'b1;
      end
      if (ld_cur) cur <= wdata;
      if (ld_div) div <= wdata;
    end
  end
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq #(
  parameter int NM = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_we,
  input  logic          mask_we,
  input  logic [NM-1:0] wbits,
  input  logic [NM-1:0] hits,
  output logic [NM-1:0] status,
  output logic [NM-1:0] mask,
  output logic          irq
);
  logic [NM-1:0] clr;
  assign clr = ack_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | hits;
      if (mask_we) mask <= wbits;
      irq <= |(status & mask);
    end
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int W  = 16,
  parameter int NM = 6,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_region,
  input  logic [AW-1:0] bus_word,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  localparam int NCNT       = 2;
  localparam int GRP_WORDS  = 3;
  localparam int MATCH_BASE = NCNT * GRP_WORDS;

  logic                  wr_tmr, wr_int;
  logic [NM-1:0][W-1:0]  match_q;
  logic [W-1:0]          cur_v  [NCNT];
  logic [W-1:0]          div_v  [NCNT];
  ctrl_t                 ctrl_v [NCNT];
  logic [NM-1:0]         hit_v  [NCNT];
  logic [NM-1:0]         hit_any;
  logic [NM-1:0]         status, mask;
  logic [W-1:0]          rd_mux;

  assign wr_tmr = bus_wr && !bus_region;
  assign wr_int = bus_wr &&  bus_region;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int BASE = g * GRP_WORDS;
    dmt_counter #(.W(W), .NM(NM)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .ld_cur     (wr_tmr && bus_word == AW'(BASE)),
      .ld_div     (wr_tmr && bus_word == AW'(BASE + 1)),
      .ld_ctrl    (wr_tmr && bus_word == AW'(BASE + 2)),
      .wdata      (bus_wdata),
      .match_vals (match_q),
      .cur        (cur_v[g]),
      .div        (div_v[g]),
      .ctrl       (ctrl_v[g]),
      .hit        (hit_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else begin
      for (int i = 0; i < NM; i++) begin
        if (wr_tmr && bus_word == AW'(MATCH_BASE + i)) match_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    hit_any = '0;
    for (int g = 0; g < NCNT; g++) hit_any = hit_any | hit_v[g];
  end

  dmt_irq #(.NM(NM)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ack_we  (wr_int && bus_word == AW'(0)),
    .mask_we (wr_int && bus_word == AW'(1)),
    .wbits   (bus_wdata[NM-1:0]),
    .hits    (hit_any),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_region) begin
      if (bus_word == AW'(0)) rd_mux = W'(status);
      if (bus_word == AW'(1)) rd_mux = W'(mask);
    end else begin
      for (int g = 0; g < NCNT; g++) begin
        if (bus_word == AW'(g * GRP_WORDS))     rd_mux = cur_v[g];
        if (bus_word == AW'(g * GRP_WORDS + 1)) rd_mux = div_v[g];
        if (bus_word == AW'(g * GRP_WORDS + 2)) rd_mux = W'(ctrl_v[g]);
      end
      for (int i = 0; i < NM; i++) begin
        if (bus_word == AW'(MATCH_BASE + i)) rd_mux = match_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int W  = 16,
  parameter int NM = 6,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_region,
  input logic [AW-1:0] bus_word,
  input logic [W-1:0]  bus_wdata,
  input logic          irq,
  input logic [NM-1:0] status,
  input logic [NM-1:0] mask,
  input logic [NM-1:0] hit_any,
  input logic [NM-1:0] hit0,
  input logic [NM-1:0] hit1,
  input logic [W-1:0]  cur0,
  input logic          stop0
);
  logic started;
  always_ff @(posedge clk) started <= !rst;

  // R2: a stopped counter that sees no bus write keeps its value
  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (rst || !started)
    (stop0 && !bus_wr) |=> (cur0 == $past(cur0)));

  // R5: at most one compare event per counter per cycle
  assert_one_hit_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit0) && $onehot0(hit1));

  // R8: no mask bit enabled means no interrupt on the next cycle
  assert_mask_gates_R8: assert property (@(posedge clk) disable iff (rst || !started)
    (mask == '0) |=> !irq);

  // R9: a write-one clear with no event leaves the written bits clear
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst || !started)
    (bus_wr && bus_region && bus_word == AW'(0) && hit_any == '0)
      |=> ((status & $past(bus_wdata[NM-1:0])) == '0));

  // R10: an event always leaves its status bit set, even against a clear
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst || !started)
    (hit_any != '0) |=> ((status & $past(hit_any)) == $past(hit_any)));
endmodule

bind dual_match_timer dmt_checker #(.W(W), .NM(NM), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_region (bus_region),
  .bus_word   (bus_word),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .status     (status),
  .mask       (mask),
  .hit_any    (hit_any),
  .hit0       (hit_v[0]),
  .hit1       (hit_v[1]),
  .cur0       (cur_v[0]),
  .stop0      (ctrl_v[0].stop)
);

// File: tb/dual_match_timer_bench.sv
`timescale 1ns/1ps
module dual_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_region = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  dual_match_timer u_dual_match_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_region(bus_region), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", bus_rdata, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  // All tasks are called at a falling edge; the operation lands on the next rising edge
  task automatic wr(input logic reg_n, input logic [3:0] w, input logic [15:0] d);
    bus_region = reg_n; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic reg_n, input logic [3:0] w, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_region = reg_n; bus_word = w; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    check(irq == e, t, {15'd0, irq}, {15'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(0, 4'd0, 16'h0000, "R1 cur0 reset");
    rd(0, 4'd2, 16'h0010, "R1 ctrl0 reset");
    rd(0, 4'd5, 16'h0010, "R1 ctrl1 reset");
    rd(1, 4'd0, 16'h0000, "R1 status reset");
    rd(1, 4'd1, 16'h0000, "R1 mask reset");

    // R2 map and load
    wr(0, 4'd4, 16'h1234);
    rd(0, 4'd4, 16'h1234, "R2 div1 readback");
    wr(0, 4'd4, 16'h0000);
    wr(0, 4'd11, 16'hBEEF);
    rd(0, 4'd11, 16'hBEEF, "R2 match5 readback");
    wr(0, 4'd0, 16'h00A5);
    idle(4);
    rd(0, 4'd0, 16'h00A5, "R2 stopped counter holds loaded value");

    // R5 count down to compare 0, hold
    wr(0, 4'd6, 16'h0000);
    wr(0, 4'd0, 16'h0005);
    wr(0, 4'd2, 16'h0001);
    idle(20);
    rd(0, 4'd0, 16'h0000, "R5 counter holds at match");
    rd(1, 4'd0, 16'h0001, "R5 status bit0 set");
    // R8 masked: latched but no irq
    chk_irq(1'b0, "R8 irq low while masked");
    wr(1, 4'd1, 16'h0001);
    idle(2);
    chk_irq(1'b1, "R8 irq high when unmasked");
    // R9 write-one clear
    wr(1, 4'd0, 16'h0001);
    idle(2);
    rd(1, 4'd0, 16'h0000, "R9 status cleared");
    chk_irq(1'b0, "R9 irq low after clear");

    // R3 / R11 counter 1 counts up to compare 3
    wr(0, 4'd9, 16'h0020);
    wr(0, 4'd3, 16'h0010);
    wr(0, 4'd5, 16'h000C);
    idle(30);
    rd(0, 4'd3, 16'h0020, "R3 counter1 counted up to match3");
    rd(1, 4'd0, 16'h0008, "R11 counter1 sets status bit3");
    rd(0, 4'd0, 16'h0000, "R11 counter0 untouched by counter1");
    wr(1, 4'd0, 16'h0000);
    rd(1, 4'd0, 16'h0008, "R9 writing zero leaves status");
    wr(1, 4'd0, 16'h003F);
    rd(1, 4'd0, 16'h0000, "R9 0x3F clears all");

    // R6 count to zero, no status
    wr(0, 4'd0, 16'h0003);
    wr(0, 4'd2, 16'h0000);
    idle(10);
    rd(0, 4'd0, 16'h0000, "R6 holds at zero");
    rd(1, 4'd0, 16'h0000, "R6 no status bit");

    // R4 divider 3: steps at edges 4 and 8 before the stop write at edge 12
    wr(0, 4'd1, 16'h0003);
    wr(0, 4'd0, 16'h0008);
    wr(0, 4'd2, 16'h0000);
    idle(11);
    wr(0, 4'd2, 16'h0010);
    rd(0, 4'd0, 16'h0006, "R4 divider paces steps");
    wr(0, 4'd1, 16'h0000);

    // R7 forever, wrap up and down
    wr(0, 4'd0, 16'hFFFE);
    wr(0, 4'd2, 16'h000F);
    idle(3);
    wr(0, 4'd2, 16'h0010);
    rd(0, 4'd0, 16'h0001, "R7 wrap counting up");
    wr(0, 4'd0, 16'h0001);
    wr(0, 4'd2, 16'h0007);
    idle(2);
    wr(0, 4'd2, 16'h0010);
    rd(0, 4'd0, 16'hFFFF, "R7 wrap counting down");

    // R10 clear lands on the compare event edge (edge 4 after control write)
    wr(0, 4'd0, 16'h0003);
    wr(0, 4'd2, 16'h0001);
    idle(3);
    wr(1, 4'd0, 16'h0001);
    idle(2);
    rd(1, 4'd0, 16'h0001, "R10 event wins over clear");
    idle(2);
    chk_irq(1'b1, "R10 irq still asserted");

    idle(3);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule